// File: doc/BRIEF.md
# Fixed-Point LMS Adaptive FIR Filter

This block is a 16-tap direct-form FIR filter whose coefficients train themselves on chip with the least-mean-square rule. All arithmetic is integer. Real values are held as integers scaled by 2^FRAC. Each sample is presented as a pair: an input sample `u` and a desired reference `d`. The block returns the filter output `y` and the estimation error `e = d - y`. On the same clock edge it moves every weight one step along the error gradient, so the next sample sees the trained coefficients.

Any product of two scaled quantities is brought back to the common scale by an arithmetic right shift of FRAC bits. Sums and differences need no correction. The learning rate is a power-of-two divisor. The weight increment is the tap-by-error product shifted right by FRAC+STEP_SHIFT, which rounds toward negative infinity. The filter accepts one sample per clock while `in_valid_i` is high. One cycle later it presents the result with a single-cycle `out_valid_o` pulse.

Top module: `lms_fir_adapt`

## Requirements
- R1: While `rst_ni` is low, `y_o`, `e_o` and `out_valid_o` are 0, and all weights and delay-line entries are cleared. The first sample after reset therefore yields `y_o` = 0.
- R2: `in_ready_o` is always 1. Every clock edge with `in_valid_i` high accepts one sample, and `out_valid_o` is high in exactly the cycle after it.
- R3: For an accepted sample, `y_o` = floor(Σ x_k·w_k / 2^FRAC), saturated to signed DW bits. Here x_0 is the current `u_i`, x_k is the `u_i` accepted k samples earlier (0 if fewer exist), and w_k are the weights from before this sample.
- R4: `e_o` = `d_i` − `y_o` of the same sample, saturated to the signed DW-bit range [−32768, 32767].
- R5: On each accept, every weight becomes w_k + floor(x_k·e / 2^(FRAC+STEP_SHIFT)), where e is the saturated error of that sample. The new weights take effect from the next accepted sample.
- R6: Weights saturate at −32768 and 32767 instead of wrapping.
- R7: A cycle with `in_valid_i` low changes no state. `y_o` and `e_o` hold, `out_valid_o` is 0, and the weights and delay line are unchanged, as the next accepted sample shows.
- R8: The output of a sample is formed with the weights from before that sample's own update, even when samples arrive back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Sample present on `u_i`/`d_i` |
| in_ready_o | output | 1 | Always ready |
| u_i | input | DW (16) | Input sample, signed, scaled by 2^FRAC |
| d_i | input | DW (16) | Desired reference, signed, scaled by 2^FRAC |
| out_valid_o | output | 1 | Result pulse, one cycle after accept |
| y_o | output | DW (16) | Filter output, signed |
| e_o | output | DW (16) | Estimation error, signed |

## Verification
Two things fall in the same cycle: the output convolution uses the current weights, and the weight update commits on the edge that registers that output. Back-to-back accepts make them meet on every edge. The bench judges each output against a model that forms `y` and `e` from the previous weights and only then applies the update. A design that filtered with freshly updated weights, or updated with a stale error, diverges within a few samples. Full-scale inputs drive the weights and the error into saturation in that same overlapped cycle, and samples separated by idle cycles confirm that nothing moves between accepts.

// File: rtl/lms_pkg.sv
package lms_pkg;
  localparam int unsigned WIDE_W = 64;
  typedef logic signed [WIDE_W-1:0] wide_t;
endpackage

// File: rtl/lms_sat.sv
module lms_sat #(
  parameter int unsigned IW = 64,
  parameter int unsigned OW = 16
) (
  input  logic signed [IW-1:0] in_i,
  output logic signed [OW-1:0] out_o
);
  localparam logic signed [IW-1:0] MAXV = IW'((64'sd1 <<< (OW-1)) - 64'sd1);
  localparam logic signed [IW-1:0] MINV = -MAXV - IW'(1);

  always_comb begin
    if (in_i > MAXV)      out_o = OW'(MAXV);
    else if (in_i < MINV) out_o = OW'(MINV);
    else                  out_o = in_i[OW-1:0];
  end
endmodule

// File: rtl/lms_delay_line.sv
module lms_delay_line #(
  parameter int unsigned NTAPS = 16,
  parameter int unsigned DW    = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic [DW-1:0]             u_i,
  output logic [NTAPS-1:0][DW-1:0]  taps_o
);
  logic [NTAPS-2:0][DW-1:0] dly_q;

  assign taps_o[0] = u_i;

  for (genvar k = 0; k < NTAPS-1; k++) begin : g_stage
    assign taps_o[k+1] = dly_q[k];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   dly_q[k] <= '0;
      else if (en_i) dly_q[k] <= taps_o[k];
    end
  end
endmodule

// File: rtl/lms_mac.sv
module lms_mac
  import lms_pkg::*;
#(
  parameter int unsigned NTAPS = 16,
  parameter int unsigned DW    = 16,
  parameter int unsigned FRAC  = 7
) (
  input  logic [NTAPS-1:0][DW-1:0] taps_i,
  input  logic [NTAPS-1:0][DW-1:0] w_i,
  input  logic signed [DW-1:0]     d_i,
  output logic signed [DW-1:0]     y_o,
  output logic signed [DW-1:0]     e_o
);
  wide_t acc, y_full, e_full;

  always_comb begin
    acc = '0;
    for (int k = 0; k < NTAPS; k++) begin
      acc = acc + (WIDE_W'(signed'(taps_i[k])) * WIDE_W'(signed'(w_i[k])));
    end
    y_full = acc >>> FRAC;
  end

  lms_sat #(.IW(WIDE_W), .OW(DW)) u_sat_y (.in_i(y_full), .out_o(y_o));

  assign e_full = WIDE_W'(d_i) - WIDE_W'(y_o);

  lms_sat #(.IW(WIDE_W), .OW(DW)) u_sat_e (.in_i(e_full), .out_o(e_o));
endmodule

// File: rtl/lms_weight_bank.sv
module lms_weight_bank
  import lms_pkg::*;
#(
  parameter int unsigned NTAPS      = 16,
  parameter int unsigned DW         = 16,
  parameter int unsigned FRAC       = 7,
  parameter int unsigned STEP_SHIFT = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic [NTAPS-1:0][DW-1:0] taps_i,
  input  logic signed [DW-1:0]     e_i,
  output logic [NTAPS-1:0][DW-1:0] w_o
);
  localparam int unsigned SHIFT = FRAC + STEP_SHIFT;

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    wide_t prod, sum;
    logic signed [DW-1:0] w_nxt, w_q;

    // floor division by 2^SHIFT via arithmetic shift
    assign prod = (WIDE_W'(signed'(taps_i[k])) * WIDE_W'(e_i)) >>> SHIFT;
    assign sum  = WIDE_W'(w_q) + prod;

    lms_sat #(.IW(WIDE_W), .OW(DW)) u_sat_w (.in_i(sum), .out_o(w_nxt));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   w_q <= '0;
      else if (en_i) w_q <= w_nxt;
    end

    assign w_o[k] = w_q;
  end
endmodule

// File: rtl/lms_fir_adapt.sv
module lms_fir_adapt #(
  parameter int unsigned NTAPS      = 16,
  parameter int unsigned DW         = 16,
  parameter int unsigned FRAC       = 7,
  parameter int unsigned STEP_SHIFT = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  input  logic signed [DW-1:0] u_i,
  input  logic signed [DW-1:0] d_i,
  output logic                 out_valid_o,
  output logic signed [DW-1:0] y_o,
  output logic signed [DW-1:0] e_o
);
  logic                     accept;
  logic [NTAPS-1:0][DW-1:0] taps;
  logic [NTAPS-1:0][DW-1:0] w_q;
  logic signed [DW-1:0]     y_c, e_c;

  assign in_ready_o = 1'b1;
  assign accept     = in_valid_i & in_ready_o;

  lms_delay_line #(.NTAPS(NTAPS), .DW(DW)) u_dly (
    .clk_i, .rst_ni, .en_i(accept), .u_i(u_i), .taps_o(taps)
  );

  lms_mac #(.NTAPS(NTAPS), .DW(DW), .FRAC(FRAC)) u_mac (
    .taps_i(taps), .w_i(w_q), .d_i(d_i), .y_o(y_c), .e_o(e_c)
  );

  lms_weight_bank #(.NTAPS(NTAPS), .DW(DW), .FRAC(FRAC), .STEP_SHIFT(STEP_SHIFT)) u_wb (
    .clk_i, .rst_ni, .en_i(accept), .taps_i(taps), .e_i(e_c), .w_o(w_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      y_o         <= '0;
      e_o         <= '0;
    end else begin
      out_valid_o <= accept;
      if (accept) begin
        y_o <= y_c;
        e_o <= e_c;
      end
    end
  end
endmodule

// File: rtl/lms_fir_adapt_chk.sv
module lms_fir_adapt_chk #(
  parameter int unsigned NTAPS = 16,
  parameter int unsigned DW    = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     in_valid_i,
  input logic signed [DW-1:0]     d_i,
  input logic                     out_valid_o,
  input logic signed [DW-1:0]     y_o,
  input logic signed [DW-1:0]     e_o,
  input logic [NTAPS-1:0][DW-1:0] w_i
);
  logic signed [DW-1:0] d_q;
  logic signed [DW:0]   diff;
  logic signed [DW-1:0] e_exp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) d_q <= '0;
    else         d_q <= d_i;
  end

  assign diff = {d_q[DW-1], d_q} - {y_o[DW-1], y_o};
  always_comb begin
    if (diff[DW] != diff[DW-1]) e_exp = diff[DW] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
    else                        e_exp = diff[DW-1:0];
  end

  p_valid_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  p_idle_no_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  p_err_relation_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (e_o == e_exp));
  p_weights_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(w_i));
  p_outputs_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($stable(y_o) && $stable(e_o)));
endmodule

bind lms_fir_adapt lms_fir_adapt_chk #(.NTAPS(NTAPS), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .d_i(d_i),
  .out_valid_o(out_valid_o), .y_o(y_o), .e_o(e_o), .w_i(w_q)
);

// File: tb/tb_lms_fir_adapt.sv
`timescale 1ns/1ps
module tb_lms_fir_adapt;
  localparam int NT = 16;
  localparam int FR = 7;
  localparam int SS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready, out_valid;
  logic signed [15:0] u, d, y, e;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  int m_w [NT];
  int m_h [NT];
  int m_y = 0, m_e = 0;

  always #5 clk = ~clk;

  lms_fir_adapt dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .u_i(u), .d_i(d), .out_valid_o(out_valid), .y_o(y), .e_o(e)
  );

  function automatic longint sat16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic void model_reset();
    for (int k = 0; k < NT; k++) begin m_w[k] = 0; m_h[k] = 0; end
    m_y = 0; m_e = 0;
  endfunction

  function automatic void model_step(int uu, int dd);
    longint acc = 0;
    for (int k = NT-1; k > 0; k--) m_h[k] = m_h[k-1];
    m_h[0] = uu;
    for (int k = 0; k < NT; k++) acc += longint'(m_h[k]) * longint'(m_w[k]);
    m_y = int'(sat16(acc >>> FR));
    m_e = int'(sat16(longint'(dd) - longint'(m_y)));
    for (int k = 0; k < NT; k++)
      m_w[k] = int'(sat16(longint'(m_w[k]) + ((longint'(m_h[k]) * longint'(m_e)) >>> (FR+SS))));
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // at a negedge: drive, wait one cycle, check at next negedge
  task automatic step(bit v, int uu, int dd, string req);
    in_valid = v; u = 16'(uu); d = 16'(dd);
    if (v) model_step(uu, dd);
    @(negedge clk);
    chk({req, " R2 valid"}, int'(out_valid), int'(v));
    chk({req, " y"}, int'(y), m_y);
    chk({req, " e"}, int'(e), m_e);
    in_valid = 1'b0;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int s;
    u = '0; d = '0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rst valid", int'(out_valid), 0);
    chk("R1 rst y", int'(y), 0);
    chk("R1 rst e", int'(e), 0);
    chk("R2 ready", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    step(0, 0, 0, "R7 idle");
    // R1 first sample sees zero weights
    step(1, 1000, 500, "R1 first");
    // impulse response build-up, back-to-back (R3 R5 R8)
    for (int i = 0; i < 20; i++) step(1, (i == 0) ? 4096 : 0, 2048, "R8 b2b");
    // R7 idle gaps must not disturb state
    for (int i = 0; i < 5; i++) step(0, 12345, -999, "R7 gap");
    step(1, 300, -300, "R7 after gap");

    // pseudo-random sweep with idle cycles (R3 R4 R5)
    s = 32'h1234;
    for (int i = 0; i < 400; i++) begin
      s = s * 1103515245 + 12345;
      if (i % 7 == 3) step(0, s >>> 16, s, "R7 sweep idle");
      else step(1, (s >>> 16) % 4096, ((s >>> 8) % 8192), "R3 R5 sweep");
    end

    // full-scale drive: weights and output saturate (R6)
    for (int i = 0; i < 40; i++) step(1, 32767, 32767, "R6 sat up");
    for (int i = 0; i < 40; i++) step(1, 32767, -32768, "R6 sat down");
    for (int i = 0; i < 30; i++) step(1, (i % 2) ? -32768 : 32767, (i % 3) ? 32767 : -32768, "R6 alt");

    // extreme grid for error saturation (R4)
    for (int a = 0; a < 5; a++)
      for (int b = 0; b < 5; b++) begin
        int va, vb;
        va = (a == 0) ? -32768 : (a == 1) ? -1 : (a == 2) ? 0 : (a == 3) ? 1 : 32767;
        vb = (b == 0) ? -32768 : (b == 1) ? -1 : (b == 2) ? 0 : (b == 3) ? 1 : 32767;
        step(1, va, vb, "R4 grid");
      end

    // mid-run reset clears everything (R1)
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    chk("R1 mid rst valid", int'(out_valid), 0);
    chk("R1 mid rst y", int'(y), 0);
    chk("R1 mid rst e", int'(e), 0);
    rst_n = 1'b1;
    @(negedge clk);
    step(1, 20000, 100, "R1 post rst");
    for (int i = 0; i < 30; i++) step(1, (i * 977) % 8000 - 4000, 1500, "R5 post rst");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule